// File: doc/BRIEF.md
# NOR Flash Completion Status Poller

This block runs after a program or erase command has been issued to a parallel NOR flash. It decides when the embedded operation inside the flash has finished and whether it succeeded. It then reports one of three outcomes: success, error or timeout.

First, the block watches the flash ready/busy line. It waits for the line to fall and then for it to rise again. Each of these waits is bounded. After that it polls the status word. It fetches the word through a request/response read port, and each polling step fetches it twice in a row. If the toggle bit (bit 6) is the same in both fetches, the flash is idle and the operation is complete. If the toggle bit differs, the block makes a second pair of fetches to confirm. The block declares an error only when the toggle bit still moves in that second pair and the error bit (bit 5) is set.

The caller picks the operation class with `op_sel_i` when it pulses `start_i`. The class selects one of three timeout limits. The limits are parameters; chip erase has the largest limit and word program the smallest.

Top module: `nor_status_poller`

## Requirements
- R1: The first wait lasts while `rdy_busy_i` is high, and the second lasts while it is low. Each wait holds for at most L cycles, where L is the limit of the selected class. The counter is reloaded with L between the two waits. When the line stays at one level, the first read request appears L+3 cycles after the start edge. When the line is low and is first sampled high at edge k after the start edge, the first request appears at edge k+1.
- R2: A polling step fetches two status words. If bit 6 is equal in both, the block finishes with result 2'b00 (success) after those two reads.
- R3: If bit 6 differs in the first pair, the block fetches a second pair. If bit 6 is equal in the second pair, the result is 2'b00 after four reads in that step.
- R4: If bit 6 differs in both pairs and bit 5 of the third read of the step is set, the result is 2'b01 (error).
- R5: Bit 5 set only in the first pair does not end the operation. The block moves on to the next polling step.
- R6: The poll counter is reloaded with L and is decremented once per polling step. Once it has reached zero and neither success nor error has been decided, the result is 2'b10 (timeout) after exactly 4·L reads. Code 2'b11 is never produced.
- R7: `op_sel_i` selects the limit as follows: 0 is word program (TO_PROG), 1 is block erase (TO_BLOCK), and 2 or 3 is chip erase (TO_CHIP). The value is captured on the start edge.
- R8: `done_o` is a one-cycle pulse. `busy_o` is high from the cycle after a start until the done pulse. `result_o` changes only in the cycle `done_o` is high, and it holds its value until the next done pulse.
- R9: A `start_i` pulse while `busy_o` is high is ignored. The running operation keeps its limit and its read count, and it produces exactly one done pulse.
- R10: A read request, once asserted, stays valid until `rd_req_ready_i` accepts it. Only one read is outstanding at a time. `rd_rsp_ready_o` is high only while the block waits for the response to an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin completion tracking (ignored while busy) |
| op_sel_i | input | 2 | Operation class: 0 program, 1 block erase, 2/3 chip erase |
| rdy_busy_i | input | 1 | Flash ready/busy line, low while busy |
| rd_req_valid_o | output | 1 | Status-word read request valid |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_rsp_valid_i | input | 1 | Read response valid |
| rd_rsp_data_i | input | DW | Status word returned by the read |
| rd_rsp_ready_o | output | 1 | Block can accept the read response |
| busy_o | output | 1 | Tracking in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 00 success, 01 error, 10 timeout |

## Verification
The hardest case to reach from the ports is a decision that lands on a chosen polling step and a chosen read of that step. A further difficulty is telling apart an error bit seen in the first pair from one seen in the confirming pair. The bench sets up a table of status words that toggle bit 6 on every read and carry noise in the unrelated bits. It then alters the four words of one selected step so that it matches, confirms, errors or passes with a harmless bit 5. It sweeps that step over every position up to the limit of each operation class, with back-pressure on the request side in every other run. Pre-wait latency is checked separately by holding or releasing the ready/busy line at counted edges.

// File: rtl/nsp_pkg.sv
package nsp_pkg;
  typedef enum logic [1:0] {
    RES_OK  = 2'b00,
    RES_ERR = 2'b01,
    RES_TMO = 2'b10
  } nsp_res_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WLOW,
    ST_WHIGH,
    ST_STEP,
    ST_REQ,
    ST_RSP
  } nsp_state_e;
endpackage

// File: rtl/nsp_limit_sel.sv
module nsp_limit_sel #(
  parameter int unsigned W        = 30,
  parameter int unsigned TO_PROG  = 5120,
  parameter int unsigned TO_BLOCK = 10485760,
  parameter int unsigned TO_CHIP  = 805306368
) (
  input  logic [1:0]   op,
  output logic [W-1:0] limit
);
  // R7: class to limit mapping
  always_comb begin
    unique case (op)
      2'd0:    limit = W'(TO_PROG);
      2'd1:    limit = W'(TO_BLOCK);
      default: limit = W'(TO_CHIP);
    endcase
  end
endmodule

// File: rtl/nsp_down_cnt.sv
module nsp_down_cnt #(
  parameter int unsigned W = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/nsp_toggle_judge.sv
module nsp_toggle_judge #(
  parameter int unsigned DW      = 16,
  parameter int unsigned TOG_BIT = 6,
  parameter int unsigned ERR_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_first,
  input  logic [DW-1:0] word,
  output logic          toggled,
  output logic          err_seen
);
  logic tog_q, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
      err_q <= 1'b0;
    end else if (cap_first) begin
      tog_q <= word[TOG_BIT];
      err_q <= word[ERR_BIT];
    end
  end

  assign toggled  = tog_q ^ word[TOG_BIT];
  assign err_seen = err_q;
endmodule

// File: rtl/nor_status_poller.sv
module nor_status_poller #(
  parameter int unsigned DW       = 16,
  parameter int unsigned TOG_BIT  = 6,
  parameter int unsigned ERR_BIT  = 5,
  parameter int unsigned TO_PROG  = 5120,
  parameter int unsigned TO_BLOCK = 10485760,
  parameter int unsigned TO_CHIP  = 805306368
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    op_sel_i,
  input  logic          rdy_busy_i,
  output logic          rd_req_valid_o,
  input  logic          rd_req_ready_i,
  input  logic          rd_rsp_valid_i,
  input  logic [DW-1:0] rd_rsp_data_i,
  output logic          rd_rsp_ready_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    result_o
);
  import nsp_pkg::*;

  localparam int unsigned MAXL = (TO_CHIP > TO_BLOCK) ?
                                 ((TO_CHIP > TO_PROG) ? TO_CHIP : TO_PROG) :
                                 ((TO_BLOCK > TO_PROG) ? TO_BLOCK : TO_PROG);
  localparam int unsigned CW = (MAXL < 2) ? 1 : $clog2(MAXL + 1);

  nsp_state_e   st_q;
  logic [1:0]   op_q;
  logic [1:0]   rd_idx_q;
  logic [CW-1:0] limit;
  logic         cnt_zero, cnt_load, cnt_dec;
  logic         wlow_stay, whigh_stay;
  logic         rsp_fire, cap_first, toggled, err_seen;

  // R7: class sampled at start, held for reloads
  nsp_limit_sel #(.W(CW), .TO_PROG(TO_PROG), .TO_BLOCK(TO_BLOCK), .TO_CHIP(TO_CHIP))
    u_lim (.op((st_q == ST_IDLE) ? op_sel_i : op_q), .limit(limit));

  // R1: wait phases continue only while the line level holds and budget remains
  assign wlow_stay  = rdy_busy_i  && !cnt_zero;
  assign whigh_stay = !rdy_busy_i && !cnt_zero;

  assign cnt_load = ((st_q == ST_IDLE)  && start_i) ||
                    ((st_q == ST_WLOW)  && !wlow_stay) ||
                    ((st_q == ST_WHIGH) && !whigh_stay);
  assign cnt_dec  = ((st_q == ST_WLOW)  && wlow_stay) ||
                    ((st_q == ST_WHIGH) && whigh_stay) ||
                    ((st_q == ST_STEP)  && !cnt_zero);   // R6: one per polling step

  nsp_down_cnt #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(limit),
    .dec(cnt_dec), .zero(cnt_zero)
  );

  assign rsp_fire  = (st_q == ST_RSP) && rd_rsp_valid_i;
  assign cap_first = rsp_fire && !rd_idx_q[0];

  nsp_toggle_judge #(.DW(DW), .TOG_BIT(TOG_BIT), .ERR_BIT(ERR_BIT)) u_judge (
    .clk(clk), .rst_n(rst_n), .cap_first(cap_first), .word(rd_rsp_data_i),
    .toggled(toggled), .err_seen(err_seen)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      op_q     <= 2'd0;
      rd_idx_q <= 2'd0;
      done_o   <= 1'b0;
      result_o <= RES_OK;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin          // R9: start only sampled here
          op_q <= op_sel_i;
          st_q <= ST_WLOW;
        end
        ST_WLOW:  if (!wlow_stay)  st_q <= ST_WHIGH;
        ST_WHIGH: if (!whigh_stay) st_q <= ST_STEP;
        ST_STEP: begin
          if (cnt_zero) begin                 // R6: budget spent
            done_o   <= 1'b1;
            result_o <= RES_TMO;
            st_q     <= ST_IDLE;
          end else begin
            rd_idx_q <= 2'd0;
            st_q     <= ST_REQ;
          end
        end
        ST_REQ: if (rd_req_ready_i) st_q <= ST_RSP;   // R10
        ST_RSP: if (rd_rsp_valid_i) begin
          if (!rd_idx_q[0]) begin
            rd_idx_q <= rd_idx_q + 2'd1;
            st_q     <= ST_REQ;
          end else if (!toggled) begin        // R2 / R3
            done_o   <= 1'b1;
            result_o <= RES_OK;
            st_q     <= ST_IDLE;
          end else if (!rd_idx_q[1]) begin    // confirm with second pair
            rd_idx_q <= 2'd2;
            st_q     <= ST_REQ;
          end else if (err_seen) begin        // R4
            done_o   <= 1'b1;
            result_o <= RES_ERR;
            st_q     <= ST_IDLE;
          end else begin                      // R5
            st_q <= ST_STEP;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req_valid_o = (st_q == ST_REQ);
  assign rd_rsp_ready_o = (st_q == ST_RSP);
  assign busy_o         = (st_q != ST_IDLE);
endmodule

// File: rtl/nsp_poller_chk.sv
module nsp_poller_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       rd_req_valid_o,
  input logic       rd_req_ready_i,
  input logic       rd_rsp_ready_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] result_o
);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));
  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!rd_req_valid_o && !rd_rsp_ready_o));
  a_r9_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid_o && !rd_req_ready_i) |=> rd_req_valid_o);
  a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid_o |-> !rd_rsp_ready_o);
  a_r10_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_rsp_ready_o) |-> $past(rd_req_valid_o && rd_req_ready_i));
  a_r6_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (result_o != 2'b11));
endmodule

bind nor_status_poller nsp_poller_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i),
  .rd_req_valid_o(rd_req_valid_o), .rd_req_ready_i(rd_req_ready_i),
  .rd_rsp_ready_o(rd_rsp_ready_o), .busy_o(busy_o),
  .done_o(done_o), .result_o(result_o)
);

// File: tb/tb_nor_status_poller.sv
module tb_nor_status_poller;
  localparam int CLK_PERIOD = 10;
  localparam int L_PROG = 4, L_BLK = 6, L_CHIP = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, rdy_busy_i = 1'b1, rd_req_ready_i = 1'b1;
  logic [1:0] op_sel_i = 2'd0;
  logic rd_rsp_valid_i = 1'b0;
  logic [15:0] rd_rsp_data_i = '0;
  logic rd_req_valid_o, rd_rsp_ready_o, busy_o, done_o;
  logic [1:0] result_o;

  int checks = 0, fails = 0, cyc = 0, rd_tot = 0, rd_base = 0;
  logic stall_en = 1'b0;
  logic [15:0] mem [0:63];

  nor_status_poller #(.TO_PROG(L_PROG), .TO_BLOCK(L_BLK), .TO_CHIP(L_CHIP)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_rsp_valid_i && rd_rsp_ready_o) rd_tot <= rd_tot + 1;
  end

  // read responder and request back-pressure
  always @(negedge clk) begin
    rd_req_ready_i = stall_en ? cyc[0] : 1'b1;
    rd_rsp_valid_i = rd_rsp_ready_o;
    rd_rsp_data_i  = mem[(rd_tot - rd_base) & 63];
  end

  always @(posedge clk) if (cyc > 150000) begin
    $display("FAIL watchdog: actual=expired expected=finish");
    fails = fails + 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails + 0);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lim(input int op);
    return (op == 0) ? L_PROG : (op == 1) ? L_BLK : L_CHIP;
  endfunction

  // table: bit6 toggles every read, noise elsewhere, one step altered
  task automatic fill(input int step, input int outcome);
    for (int k = 0; k < 64; k++)
      mem[k] = (16'((k * 37) + 11) & 16'hFF9F) | (k[0] ? 16'h0040 : 16'h0000);
    case (outcome)
      0: mem[4*step+1][6] = mem[4*step][6];
      1: mem[4*step+3][6] = mem[4*step+2][6];
      2: mem[4*step+2][5] = 1'b1;
      default: begin mem[4*step][5] = 1'b1; mem[4*step+1][5] = 1'b1; end
    endcase
  endtask

  // expected outcome derived from the requirement rules
  task automatic model(input int L, output int res, output int reads);
    res = 2; reads = 4 * L;
    for (int s = 0; s < L; s++) begin
      if (mem[4*s][6] == mem[4*s+1][6]) begin res = 0; reads = 4*s+2; return; end
      if (mem[4*s+2][6] == mem[4*s+3][6]) begin res = 0; reads = 4*s+4; return; end
      if (mem[4*s+2][5]) begin res = 1; reads = 4*s+4; return; end
    end
  endtask

  task automatic kick(input int op);
    @(negedge clk);
    rd_base = rd_tot; op_sel_i = 2'(op); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input string req, output int got);
    int n = 0;
    while (!done_o && n < 3000) begin @(negedge clk); n++; end
    chk({req, " done seen"}, int'(done_o), 1);
    got = int'(result_o);
  endtask

  task automatic run(input int op, input int step, input int outcome, input string req);
    int er, erd, got, r0;
    fill(step, outcome);
    model(lim(op), er, erd);
    kick(op);
    wait_done(req, got);
    chk({req, " result"}, got, er);
    chk({req, " read count"}, rd_tot - rd_base, erd);
    r0 = got;
    @(negedge clk);
    chk("R8 done one cycle", int'(done_o), 0);
    chk("R8 result held", int'(result_o), r0);
    chk("R8 busy cleared", int'(busy_o), 0);
  endtask

  // R1: cycles from start edge to first read request
  task automatic latency(input logic lvl, input int raise_after, input int exp);
    int c0, got;
    fill(0, 0);
    rdy_busy_i = lvl;
    @(negedge clk);
    rd_base = rd_tot; op_sel_i = 2'd0; start_i = 1'b1;
    @(posedge clk); c0 = cyc + 1;
    @(negedge clk); start_i = 1'b0;
    if (raise_after > 0) begin
      repeat (raise_after) @(posedge clk);
      @(negedge clk); rdy_busy_i = 1'b1;
    end
    while (!rd_req_valid_o && (cyc - c0) < 100) @(negedge clk);
    chk("R1 first request latency", cyc - c0, exp);
    wait_done("R1", got);
    rdy_busy_i = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int got;
    fill(0, 0);
    repeat (3) @(negedge clk);
    chk("reset done", int'(done_o), 0);
    chk("reset busy", int'(busy_o), 0);
    chk("reset req", int'(rd_req_valid_o), 0);
    chk("reset result", int'(result_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    latency(1'b1, 0, L_PROG + 3);   // R1 line stuck high
    latency(1'b0, 0, L_PROG + 3);   // R1 line stuck low
    latency(1'b0, 3, 3 + 2);        // R1 line rises before budget

    // R2 R3 R4 R5 R6 R7 sweep
    for (int op = 0; op < 4; op++)
      for (int oc = 0; oc < 4; oc++)
        for (int s = 0; s < lim(op); s++) begin
          stall_en = s[0];
          case (oc)
            0: run(op, s, oc, "R2 first pair match");
            1: run(op, s, oc, "R3 second pair match");
            2: run(op, s, oc, "R4 error confirmed");
            default: run(op, s, oc, "R5 early bit5 R6 R7");
          endcase
        end
    stall_en = 1'b0;

    // R9: restart request while busy
    fill(0, 3);
    kick(0);
    repeat (5) @(negedge clk);
    op_sel_i = 2'd2; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    wait_done("R9", got);
    chk("R9 result kept timeout", got, 2);
    chk("R9 read count of program limit", rd_tot - rd_base, 4 * L_PROG);
    @(negedge clk);
    repeat (60) begin
      chk("R9 single done", int'(done_o), 0);
      @(negedge clk);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule